// File: doc/BRIEF.md
# Effective Address Calculation Unit

This block forms the 16-bit offset of a memory operand for a 16-bit segmented processor. Each request carries an addressing-mode selector, two register selectors, the current pointer-register values, the low accumulator byte and a displacement. The block returns the offset, the segment register the access uses by default, an error flag for register choices the addressing hardware cannot encode, and the number of clocks the address calculation costs.

The block accepts one request per cycle on a valid/ready handshake and delivers the result one cycle later in an output register. That register holds while the consumer stalls. Immediate and register operands never reach the block. Instruction decoding, the register file and the bus are outside it.

Top module: `ea_calc_unit`

## Requirements
- R1: Register selectors use the codes 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI. In modes 1 and 2 the first selector must be BX, BP, SI or DI. In modes 3 and 4 the first selector must be BX or BP and the second must be SI or DI. Any other choice sets the error flag and forces offset 0, cost 0 and segment code 3.
- R2: Mode 0 (direct) returns the displacement as the offset at a cost of 6. Both selectors are ignored.
- R3: Mode 1 (one register) returns that register's value at a cost of 5.
- R4: Mode 2 (one register plus displacement) returns their sum at a cost of 9.
- R5: Mode 3 (base plus index) returns the sum of the two registers. The cost is 7 for BX with SI or BP with DI, and 8 for BX with DI or BP with SI.
- R6: Mode 4 (base plus index plus displacement) returns the three-way sum. The cost is 11 for the pairs BX/SI and BP/DI, and 12 for the other two pairs.
- R7: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS. Without an override, any mode that uses BP reports SS, and every other legal request reports DS.
- R8: Mode 5 (table lookup) returns BX plus the zero-extended accumulator byte, on DS, at a cost of 11. Both selectors are ignored.
- R9: When the override enable is set on a legal request, the override segment code replaces the default segment and the cost rises by 2.
- R10: When the short-displacement flag is set, displacement bit 7 is sign-extended over bits 15:8 before use. All sums wrap modulo 2^16.
- R11: A request accepted on a clock edge has its result valid after that edge. `req_ready` is high whenever the output is empty or is being consumed. A result that is not consumed keeps all its fields unchanged.
- R12: Modes 6 and 7 are reserved and set the error flag, with the same forced outputs as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 3 | Addressing mode selector (0..5, 6..7 reserved) |
| req_rega | input | 3 | First register selector (base or single) |
| req_regb | input | 3 | Second register selector (index) |
| req_bx | input | 16 | BX value |
| req_bp | input | 16 | BP value |
| req_si | input | 16 | SI value |
| req_di | input | 16 | DI value |
| req_al | input | 8 | Accumulator low byte |
| req_disp | input | 16 | Displacement |
| req_disp8 | input | 1 | Displacement is 8 bits, sign-extend it |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_seg | input | 2 | Override segment code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ea | output | 16 | Effective address |
| rsp_seg | output | 2 | Segment code |
| rsp_err | output | 1 | Illegal register or reserved mode |
| rsp_cost | output | 5 | Address-calculation clocks |

## Verification
Two functions meet inside a single request: the segment override and the BP-driven default segment. A third interaction arises when the error path meets an override. The sweep runs every mode and selector pair with the override both clear and set, so BP-based requests carrying an override show whether the override wins and adds exactly 2. Illegal requests carrying an override show that the error forces cost 0 and DS. A separate stall sequence holds `rsp_ready` low while a second request waits. It checks that the first result stays frozen and that the second result appears only after the first is consumed.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [2:0] {
      M_DIRECT = 3'd0,
      M_ONE    = 3'd1,
      M_ONEDSP = 3'd2,
      M_PAIR   = 3'd3,
      M_PAIRDS = 3'd4,
      M_TABLE  = 3'd5
   } ea_mode_e;

   localparam logic [2:0] RC_BX = 3'd3;
   localparam logic [2:0] RC_BP = 3'd5;
   localparam logic [2:0] RC_SI = 3'd6;
   localparam logic [2:0] RC_DI = 3'd7;

   localparam logic [1:0] SEG_SS = 2'd2;
   localparam logic [1:0] SEG_DS = 2'd3;

   localparam int C_DIRECT   = 6;
   localparam int C_ONE      = 5;
   localparam int C_ONEDSP   = 9;
   localparam int C_PAIR     = 7;
   localparam int C_PAIRDS   = 11;
   localparam int C_TABLE    = 11;
   localparam int C_SLOWPEN  = 1;
   localparam int C_OVERRIDE = 2;
   localparam int C_MAX      = C_PAIRDS + C_SLOWPEN + C_OVERRIDE;
endpackage

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
   import ea_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [2:0]        mode,
   input  logic [2:0]        rega,
   input  logic [2:0]        regb,
   input  logic [ADDR_W-1:0] bx,
   input  logic [ADDR_W-1:0] bp,
   input  logic [ADDR_W-1:0] si,
   input  logic [ADDR_W-1:0] di,
   input  logic [7:0]        al,
   input  logic [ADDR_W-1:0] disp,
   input  logic              disp8,
   output logic [ADDR_W-1:0] op_a,
   output logic [ADDR_W-1:0] op_b,
   output logic [ADDR_W-1:0] op_c,
   output logic              illegal,
   output logic              uses_bp,
   output logic              fast_pair
);
   localparam int EXT_W = ADDR_W - 8;

   logic [ADDR_W-1:0] disp_x;
   logic [ADDR_W-1:0] single_val;
   logic              single_ok;
   logic              base_ok;
   logic              index_ok;

   assign disp_x = disp8 ? {{EXT_W{disp[7]}}, disp[7:0]} : disp;

   always_comb begin
      single_ok  = 1'b1;
      single_val = '0;
      unique case (rega)
         RC_BX:   single_val = bx;
         RC_BP:   single_val = bp;
         RC_SI:   single_val = si;
         RC_DI:   single_val = di;
         default: single_ok  = 1'b0;
      endcase
   end

   assign base_ok  = (rega == RC_BX) || (rega == RC_BP);
   assign index_ok = (regb == RC_SI) || (regb == RC_DI);

   always_comb begin
      op_a      = '0;
      op_b      = '0;
      op_c      = '0;
      illegal   = 1'b0;
      uses_bp   = 1'b0;
      fast_pair = 1'b0;
      case (mode)
         M_DIRECT: op_c = disp_x;
         M_ONE, M_ONEDSP: begin
            illegal = !single_ok;
            op_a    = single_val;
            uses_bp = (rega == RC_BP);
            if (mode == M_ONEDSP) op_c = disp_x;
         end
         M_PAIR, M_PAIRDS: begin
            illegal   = !(base_ok && index_ok);
            op_a      = (rega == RC_BP) ? bp : bx;
            op_b      = (regb == RC_DI) ? di : si;
            uses_bp   = (rega == RC_BP);
            fast_pair = (rega == RC_BX && regb == RC_SI) ||
                        (rega == RC_BP && regb == RC_DI);
            if (mode == M_PAIRDS) op_c = disp_x;
         end
         M_TABLE: begin
            op_a = bx;
            op_b = {{EXT_W{1'b0}}, al};
         end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
   parameter int ADDR_W    = 16,
   parameter bit ONE_STAGE = 1'b1
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);
   generate
      if (ONE_STAGE) begin : g_flat
         assign sum = a + b + c;
      end else begin : g_split
         logic [ADDR_W-1:0] ab;
         assign ab  = a + b;
         assign sum = ab + c;
      end
   endgenerate
endmodule

// File: rtl/ea_cost_seg.sv
module ea_cost_seg
   import ea_pkg::*;
#(
   parameter int COST_W = 5
) (
   input  logic [2:0]        mode,
   input  logic              uses_bp,
   input  logic              fast_pair,
   input  logic              ovr_en,
   input  logic [1:0]        ovr_seg,
   output logic [COST_W-1:0] cost,
   output logic [1:0]        seg
);
   logic [COST_W-1:0] base_cost;

   always_comb begin
      case (mode)
         M_DIRECT: base_cost = COST_W'(C_DIRECT);
         M_ONE:    base_cost = COST_W'(C_ONE);
         M_ONEDSP: base_cost = COST_W'(C_ONEDSP);
         M_PAIR:   base_cost = fast_pair ? COST_W'(C_PAIR)   : COST_W'(C_PAIR + C_SLOWPEN);
         M_PAIRDS: base_cost = fast_pair ? COST_W'(C_PAIRDS) : COST_W'(C_PAIRDS + C_SLOWPEN);
         M_TABLE:  base_cost = COST_W'(C_TABLE);
         default:  base_cost = '0;
      endcase
   end

   assign cost = base_cost + (ovr_en ? COST_W'(C_OVERRIDE) : '0);
   assign seg  = ovr_en ? ovr_seg : (uses_bp ? SEG_SS : SEG_DS);

   always_comb begin
      if ((mode == M_PAIR) && !ovr_en)
         a_r5_pair_cost: assert (cost == COST_W'(7) || cost == COST_W'(8));
   end
endmodule

// File: rtl/ea_calc_unit.sv
module ea_calc_unit
   import ea_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int COST_W    = 5,
   parameter bit ONE_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_mode,
   input  logic [2:0]        req_rega,
   input  logic [2:0]        req_regb,
   input  logic [ADDR_W-1:0] req_bx,
   input  logic [ADDR_W-1:0] req_bp,
   input  logic [ADDR_W-1:0] req_si,
   input  logic [ADDR_W-1:0] req_di,
   input  logic [7:0]        req_al,
   input  logic [ADDR_W-1:0] req_disp,
   input  logic              req_disp8,
   input  logic              req_ovr_en,
   input  logic [1:0]        req_ovr_seg,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_ea,
   output logic [1:0]        rsp_seg,
   output logic              rsp_err,
   output logic [COST_W-1:0] rsp_cost
);
   generate
      if (ADDR_W < 9) begin : g_bad_addr_w
         $error("ea_calc_unit: ADDR_W must exceed 8");
      end
      if ((1 << COST_W) <= C_MAX) begin : g_bad_cost_w
         $error("ea_calc_unit: COST_W too narrow for the largest cost");
      end
   endgenerate

   logic [ADDR_W-1:0] op_a, op_b, op_c, sum;
   logic              illegal, uses_bp, fast_pair;
   logic [COST_W-1:0] cost;
   logic [1:0]        seg;
   logic              fire;

   ea_operand_sel #(.ADDR_W(ADDR_W)) u_sel (
      .mode(req_mode), .rega(req_rega), .regb(req_regb),
      .bx(req_bx), .bp(req_bp), .si(req_si), .di(req_di),
      .al(req_al), .disp(req_disp), .disp8(req_disp8),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .illegal(illegal), .uses_bp(uses_bp), .fast_pair(fast_pair)
   );

   ea_adder #(.ADDR_W(ADDR_W), .ONE_STAGE(ONE_STAGE)) u_add (
      .a(op_a), .b(op_b), .c(op_c), .sum(sum)
   );

   ea_cost_seg #(.COST_W(COST_W)) u_cost (
      .mode(req_mode), .uses_bp(uses_bp), .fast_pair(fast_pair),
      .ovr_en(req_ovr_en), .ovr_seg(req_ovr_seg),
      .cost(cost), .seg(seg)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign fire      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ea    <= '0;
         rsp_seg   <= SEG_DS;
         rsp_err   <= 1'b0;
         rsp_cost  <= '0;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_err  <= illegal;
            rsp_ea   <= illegal ? '0 : sum;
            rsp_seg  <= illegal ? SEG_DS : seg;
            rsp_cost <= illegal ? '0 : cost;
         end
      end
   end

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ea) &&
      $stable(rsp_cost) && $stable(rsp_seg) && $stable(rsp_err));

   a_r11_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   a_r1_err_forced: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> rsp_ea == '0 && rsp_cost == '0 && rsp_seg == SEG_DS);

   a_r1_bad_single: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (req_mode == M_ONE) &&
      (req_rega == 3'd0 || req_rega == 3'd1 || req_rega == 3'd2 || req_rega == 3'd4)
      |=> rsp_valid && rsp_err);

   a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (req_mode > 3'd5) |=> rsp_err);

   a_r9_override: assert property (@(posedge clk) disable iff (!rst_n)
      fire && req_ovr_en && (req_mode == M_DIRECT)
      |=> rsp_cost == COST_W'(C_DIRECT + C_OVERRIDE) && rsp_seg == $past(req_ovr_seg));

   a_r2_direct_ea: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (req_mode == M_DIRECT) && !req_disp8 |=> rsp_ea == $past(req_disp));
endmodule

// File: tb/ea_calc_unit_bench.sv
module ea_calc_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_mode = '0, req_rega = '0, req_regb = '0;
   logic [15:0] req_bx = '0, req_bp = '0, req_si = '0, req_di = '0, req_disp = '0;
   logic [7:0]  req_al = '0;
   logic        req_disp8 = 1'b0, req_ovr_en = 1'b0;
   logic [1:0]  req_ovr_seg = '0;
   logic        rsp_valid, rsp_err;
   logic        rsp_ready = 1'b1;
   logic [15:0] rsp_ea;
   logic [1:0]  rsp_seg;
   logic [4:0]  rsp_cost;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ea_calc_unit u_ea_calc_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_rega(req_rega), .req_regb(req_regb),
      .req_bx(req_bx), .req_bp(req_bp), .req_si(req_si), .req_di(req_di),
      .req_al(req_al), .req_disp(req_disp), .req_disp8(req_disp8),
      .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_ea(rsp_ea), .rsp_seg(rsp_seg), .rsp_err(rsp_err), .rsp_cost(rsp_cost)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rv(input logic [2:0] c);
      case (c)
         3'd3: return req_bx;
         3'd5: return req_bp;
         3'd6: return req_si;
         default: return req_di;
      endcase
   endfunction

   int e_ea, e_seg, e_err, e_cost;
   string t_mode;

   task automatic model();
      logic [15:0] d;
      bit ok1, okp, fast;
      d    = req_disp8 ? {{8{req_disp[7]}}, req_disp[7:0]} : req_disp;
      ok1  = req_rega inside {3'd3, 3'd5, 3'd6, 3'd7};
      okp  = (req_rega inside {3'd3, 3'd5}) && (req_regb inside {3'd6, 3'd7});
      fast = (req_rega == 3'd3 && req_regb == 3'd6) || (req_rega == 3'd5 && req_regb == 3'd7);
      e_err = 0; e_seg = 3; e_ea = 0; e_cost = 0;
      case (req_mode)
         3'd0: begin t_mode = "R2"; e_ea = d; e_cost = 6; end
         3'd1: begin t_mode = "R3"; e_err = !ok1; e_ea = 16'(rv(req_rega));
                     e_cost = 5; e_seg = (req_rega == 3'd5) ? 2 : 3; end
         3'd2: begin t_mode = "R4"; e_err = !ok1; e_ea = 16'(rv(req_rega) + d);
                     e_cost = 9; e_seg = (req_rega == 3'd5) ? 2 : 3; end
         3'd3: begin t_mode = "R5"; e_err = !okp; e_ea = 16'(rv(req_rega) + rv(req_regb));
                     e_cost = fast ? 7 : 8; e_seg = (req_rega == 3'd5) ? 2 : 3; end
         3'd4: begin t_mode = "R6"; e_err = !okp;
                     e_ea = 16'(rv(req_rega) + rv(req_regb) + d);
                     e_cost = fast ? 11 : 12; e_seg = (req_rega == 3'd5) ? 2 : 3; end
         3'd5: begin t_mode = "R8"; e_ea = 16'(req_bx + {8'h00, req_al}); e_cost = 11; end
         default: begin t_mode = "R12"; e_err = 1; end
      endcase
      if (e_err != 0) begin
         e_ea = 0; e_cost = 0; e_seg = 3;
         if (req_mode < 3'd6) t_mode = "R1";
      end else if (req_ovr_en) begin
         e_seg = req_ovr_seg; e_cost += 2;
      end
   endtask

   task automatic run_one(input int m, input int a, input int b, input int ov, input int d8);
      @(negedge clk);
      req_mode = 3'(m); req_rega = 3'(a); req_regb = 3'(b);
      req_ovr_en = ov[0]; req_ovr_seg = 2'($urandom_range(0, 3));
      req_disp8 = d8[0];
      req_bx = 16'($urandom); req_bp = 16'($urandom);
      req_si = 16'($urandom); req_di = 16'($urandom);
      req_al = 8'($urandom);
      req_disp = 16'($urandom);
      if (d8 != 0) req_disp[7] = (a[0] ^ b[0]);
      req_valid = 1'b1;
      model();
      @(negedge clk);
      req_valid = 1'b0;
      check({t_mode, " R11 valid"}, int'(rsp_valid), 1);
      check({t_mode, (e_err != 0) ? " err" : " R10 no-err"}, int'(rsp_err), e_err);
      check({t_mode, (d8 != 0) ? " R10 ea" : " ea"}, int'(rsp_ea), e_ea);
      check({t_mode, (ov != 0) ? " R9 seg" : " R7 seg"}, int'(rsp_seg), e_seg);
      check({t_mode, (ov != 0) ? " R9 cost" : " cost"}, int'(rsp_cost), e_cost);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] first_ea;
      repeat (3) @(negedge clk);
      check("R11 reset valid", int'(rsp_valid), 0);
      check("R11 reset ready", int'(req_ready), 1);
      check("R1 reset err", int'(rsp_err), 0);
      rst_n = 1'b1;

      for (int m = 0; m < 8; m++)
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
               for (int ov = 0; ov < 2; ov++)
                  for (int d8 = 0; d8 < 2; d8++)
                     run_one(m, a, b, ov, d8);

      // R10 wrap corner: BX=FFFF, SI=0002, disp8 = 0x80 -> -128
      @(negedge clk);
      req_mode = 3'd4; req_rega = 3'd3; req_regb = 3'd6; req_ovr_en = 1'b0;
      req_bx = 16'hFFFF; req_si = 16'h0002; req_disp = 16'h1280; req_disp8 = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 wrap ea", int'(rsp_ea), 16'hFF81);
      check("R6 fast cost", int'(rsp_cost), 11);

      // R11 backpressure: first result must hold while a second request waits
      @(negedge clk);
      rsp_ready = 1'b0;
      req_mode = 3'd0; req_disp8 = 1'b0; req_disp = 16'h1234; req_valid = 1'b1;
      @(negedge clk);
      first_ea = rsp_ea;
      check("R11 stall first ea", int'(first_ea), 16'h1234);
      req_disp = 16'h5678;
      check("R11 stall ready low", int'(req_ready), 0);
      repeat (3) @(negedge clk);
      check("R11 stall hold ea", int'(rsp_ea), 16'h1234);
      check("R11 stall hold valid", int'(rsp_valid), 1);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R11 second ea", int'(rsp_ea), 16'h5678);
      check("R11 second valid", int'(rsp_valid), 1);
      @(negedge clk);
      check("R11 drained", int'(rsp_valid), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule